// File: doc/BRIEF.md
# Disk Read Prefetch Buffer

This block sits between a 32-bit host read port and a 16-bit disk data port. While the host has a read pending, it fetches 16-bit words from the drive into a four-entry queue. It keeps fetching even when the host cannot yet take a result. The host receives either one word or two words packed into a 32-bit result, depending on the size it asks for. Drive cycles are requested with a simple request/done handshake. That handshake stands in for the disk cycle timing logic, which is not part of this block.

A byte counter limits how far prefetch runs ahead. It is loaded with the sector size and loses two bytes for every word taken from the drive. At zero, prefetch stops at the sector boundary. The counter is reloaded once a pending host request can no longer be met from the queue. When the enable input is low, prefetch is off. Each host request then fetches only the words it is missing.

The host side is two valid/ready streams. On the request stream, `rq_valid` and `rq_dword` must stay stable until `rq_ready` is seen high. `rq_ready` is high only when the queue holds enough words and the result slot is free, or is being emptied in that cycle. On the result stream, `hd_valid` and `hd_data` are held while `hd_ready` is low. While that back-pressure lasts, the block goes on prefetching.

Top module: `rdahead_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until a host request arrives, `drv_req` and `hd_valid` stay low.
- R2: With prefetch enabled, a drive cycle is issued only while `rq_valid` is high, fewer than four words are queued and the byte counter is nonzero. Only one cycle is outstanding at a time, and no drive cycle starts while the queue is full.
- R3: Each drive word accepted with prefetch enabled lowers the byte counter by two, so prefetch stops once sector-size/2 words have been fetched.
- R4: When the counter is zero and the pending request cannot be met from the queue, the counter reloads from `sector_bytes` and prefetch resumes.
- R5: A word request (`rq_dword`=0) returns the oldest queued word in `hd_data[15:0]` with bits 31:16 zero, and removes one word.
- R6: A doubleword request (`rq_dword`=1) waits until two words are queued. It returns the older word in bits 15:0 and the newer in bits 31:16, and removes both.
- R7: Host results carry the drive words in the order the drive delivered them, with none repeated or skipped except by R10.
- R8: While `hd_valid` is high and `hd_ready` is low, `hd_valid` and `hd_data` hold, and no request is accepted.
- R9: With `ra_enable` low, a request fetches only the words it lacks: one for a word and two for a doubleword from an empty queue. No drive cycle starts while no request is pending. The counter follows `sector_bytes`.
- R10: A falling edge of `ra_enable` empties the queue and discards the word of any drive cycle still in flight. The next result comes from a freshly fetched word.
- R11: `drv_req` stays high from issue until the cycle in which `drv_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_enable | input | 1 | Prefetch enable; low selects on-demand fetch |
| sector_bytes | input | CW | Bytes per sector, used as the counter reload value |
| rq_valid | input | 1 | Host read request pending |
| rq_dword | input | 1 | Request size: 1 doubleword, 0 word |
| rq_ready | output | 1 | Request accepted this cycle |
| hd_valid | output | 1 | Host result valid |
| hd_ready | input | 1 | Host takes the result |
| hd_data | output | 2*HW | Host result data |
| drv_req | output | 1 | Drive read cycle requested |
| drv_done | input | 1 | Drive cycle complete, `drv_data` valid |
| drv_data | input | HW | Word returned by the drive |

## Verification
The properties assume the following about the inputs:
- `drv_done` pulses only while `drv_req` is high.
- `sector_bytes` is even and nonzero, and changes only while prefetch is disabled.
- A request stays stable until it is accepted.

The bench's drive model answers only requests it has observed, after a chosen latency, with a one-cycle done pulse. The sector size is changed only after `ra_enable` has dropped. The request driver holds each request until it sees `rq_ready`, and drives new inputs only on the falling clock edge.

// File: rtl/rdahead_pkg.sv
package rdahead_pkg;
  typedef enum logic [1:0] {
    DRV_IDLE = 2'd0,
    DRV_WAIT = 2'd1,
    DRV_DROP = 2'd2
  } drv_state_e;
endpackage

// File: rtl/rdahead_fifo.sv
module rdahead_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop1,
  input  logic                         pop2,
  output logic [W-1:0]                 head0,
  output logic [W-1:0]                 head1,
  output logic [$clog2(DEPTH+1)-1:0]   fill
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, rd_nxt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_nxt = bump(rd_ptr);
  assign head0  = slot[rd_ptr];
  assign head1  = slot[rd_nxt];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !flush && wr_ptr == PTR_W'(g)) slot[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop2)      rd_ptr <= bump(rd_nxt);
      else if (pop1) rd_ptr <= rd_nxt;
      fill <= fill + CNT_W'(push) - (pop2 ? CNT_W'(2) : CNT_W'(pop1));
    end
  end
endmodule

// File: rtl/rdahead_sector_cnt.sv
module rdahead_sector_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          dec,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);
  localparam logic [CW-1:0] STEP = CW'(2);

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (reload) cnt <= load_val;
    else if (dec)    cnt <= (cnt >= STEP) ? cnt - STEP : '0;
  end
endmodule

// File: rtl/rdahead_drv_seq.sv
module rdahead_drv_seq
  import rdahead_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic flush,
  input  logic done,
  output logic req,
  output logic accept
);
  drv_state_e state, state_nxt;

  assign req    = (state != DRV_IDLE);
  assign accept = (state == DRV_WAIT) && done;

  always_comb begin
    state_nxt = state;
    unique case (state)
      DRV_IDLE: if (issue) state_nxt = DRV_WAIT;
      DRV_WAIT: begin
        if (done)       state_nxt = DRV_IDLE;
        else if (flush) state_nxt = DRV_DROP;
      end
      DRV_DROP: if (done) state_nxt = DRV_IDLE;
      default:  state_nxt = DRV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= DRV_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/rdahead_ctrl.sv
module rdahead_ctrl #(
  parameter int HW         = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int CW         = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ra_enable,
  input  logic [CW-1:0]   sector_bytes,
  input  logic            rq_valid,
  input  logic            rq_dword,
  output logic            rq_ready,
  output logic            hd_valid,
  input  logic            hd_ready,
  output logic [2*HW-1:0] hd_data,
  output logic            drv_req,
  input  logic            drv_done,
  input  logic [HW-1:0]   drv_data
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);
  localparam int DW    = 2*HW;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

  logic             en_q, flush;
  logic [CNT_W-1:0] fifo_fill, need;
  logic [HW-1:0]    head0, head1;
  logic             have, slot_free, serve;
  logic             pf_go, od_go, issue, reload, accept, fifo_push;
  logic [CW-1:0]    byte_cnt;
  logic             cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= ra_enable;
  end

  // prefetch switched off: drop everything queued or in flight
  assign flush     = en_q && !ra_enable;
  assign need      = rq_dword ? CNT_W'(2) : CNT_W'(1);
  assign have      = (fifo_fill >= need);
  assign slot_free = !hd_valid || hd_ready;
  assign serve     = rq_valid && have && slot_free && !flush;
  assign rq_ready  = serve;

  assign pf_go  = ra_enable && rq_valid && (fifo_fill < DEPTH_C) && !cnt_zero;
  assign od_go  = !ra_enable && rq_valid && !hd_valid && !have;
  assign issue  = (pf_go || od_go) && !drv_req && !flush;
  assign reload = !ra_enable || (cnt_zero && rq_valid && !have);
  assign fifo_push = accept && !flush;

  rdahead_fifo #(.W(HW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (fifo_push),
    .wdata (drv_data),
    .pop1  (serve && !rq_dword),
    .pop2  (serve && rq_dword),
    .head0 (head0),
    .head1 (head1),
    .fill  (fifo_fill)
  );

  rdahead_sector_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (reload),
    .dec      (fifo_push && ra_enable),
    .load_val (sector_bytes),
    .cnt      (byte_cnt),
    .zero     (cnt_zero)
  );

  rdahead_drv_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (issue),
    .flush  (flush),
    .done   (drv_done),
    .req    (drv_req),
    .accept (accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_valid <= 1'b0;
      hd_data  <= '0;
    end else if (serve) begin
      hd_valid <= 1'b1;
      hd_data  <= rq_dword ? {head1, head0} : {{(DW-HW){1'b0}}, head0};
    end else if (hd_ready) begin
      hd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rdahead_ctrl_chk.sv
module rdahead_ctrl_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter int CW    = 16,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ra_enable,
  input logic             flush,
  input logic             drv_req,
  input logic             drv_done,
  input logic             fifo_push,
  input logic             hd_valid,
  input logic             hd_ready,
  input logic [DW-1:0]    hd_data,
  input logic [CNT_W-1:0] fifo_fill,
  input logic [CW-1:0]    byte_cnt
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  a_r2_no_issue_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_req) |-> $past(fifo_fill) < DEPTH_C);

  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_fill <= DEPTH_C);

  a_r3_cnt_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_enable && !flush && fifo_push && byte_cnt >= CW'(2))
      |=> byte_cnt == $past(byte_cnt) - CW'(2));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_valid && !hd_ready) |=> (hd_valid && $stable(hd_data)));

  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fifo_fill == '0);

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_req && !drv_done) |=> drv_req);
endmodule

bind rdahead_ctrl rdahead_ctrl_chk #(
  .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .CW(CW), .DW(DW)
) i_rdahead_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ra_enable (ra_enable),
  .flush     (flush),
  .drv_req   (drv_req),
  .drv_done  (drv_done),
  .fifo_push (fifo_push),
  .hd_valid  (hd_valid),
  .hd_ready  (hd_ready),
  .hd_data   (hd_data),
  .fifo_fill (fifo_fill),
  .byte_cnt  (byte_cnt)
);

// File: tb/test_rdahead_ctrl.sv
`timescale 1ns/1ps
module test_rdahead_ctrl;
  localparam int HW = 16, DEPTH = 4, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, ra_enable = 1'b1;
  logic [CW-1:0] sector_bytes = CW'(64);
  logic rq_valid = 1'b0, rq_dword = 1'b0, rq_ready;
  logic hd_valid, hd_ready = 1'b1;
  logic [2*HW-1:0] hd_data;
  logic drv_req, drv_done = 1'b0;
  logic [HW-1:0] drv_data = '0;

  rdahead_ctrl #(.HW(HW), .FIFO_DEPTH(DEPTH), .CW(CW)) i_rdahead_ctrl (
    .clk(clk), .rst_n(rst_n), .ra_enable(ra_enable), .sector_bytes(sector_bytes),
    .rq_valid(rq_valid), .rq_dword(rq_dword), .rq_ready(rq_ready),
    .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_data(hd_data),
    .drv_req(drv_req), .drv_done(drv_done), .drv_data(drv_data));

  always #2.5 clk = ~clk;

  typedef struct { logic [31:0] data; string tag; } exp_t;
  exp_t expq[$];
  bit   cmdq[$];
  int   errors = 0, checks = 0, widx = 0, hidx = 0, drv_lat = 1, r11_bad = 0;
  bit   tag_flush = 1'b0, prev_req = 1'b0, prev_done = 1'b0;

  function automatic logic [15:0] wordval(int i);
    return {i[7:0] ^ 8'hC3, i[7:0]};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive model: answers an observed request after drv_lat cycles
  initial forever begin
    @(negedge clk);
    if (rst_n && drv_req && !drv_done) begin
      repeat (drv_lat) @(negedge clk);
      drv_data = wordval(widx);
      widx++;
      drv_done = 1'b1;
      @(negedge clk);
      drv_done = 1'b0;
    end
  end

  // request driver
  initial forever begin
    @(negedge clk);
    if (cmdq.size() > 0) begin
      rq_dword = cmdq.pop_front();
      rq_valid = 1'b1;
      #1;
      while (!rq_ready) begin @(negedge clk); #1; end
    end else begin
      rq_valid = 1'b0;
    end
  end

  // scoreboard: expected result fixed when a request is accepted, compared on handoff
  initial forever begin
    @(negedge clk); #2;
    if (rq_valid && rq_ready) begin
      exp_t e;
      e.data = rq_dword ? {wordval(hidx+1), wordval(hidx)} : {16'h0000, wordval(hidx)};
      e.tag  = tag_flush ? "R10" : (rq_dword ? "R6" : "R5");
      tag_flush = 1'b0;
      hidx += rq_dword ? 2 : 1;
      expq.push_back(e);
    end
    if (hd_valid && hd_ready) begin
      if (expq.size() == 0) chk(1'b0, "R7 unexpected result", hd_data, 32'h0);
      else begin
        exp_t e;
        e = expq.pop_front();
        chk(hd_data == e.data, e.tag, hd_data, e.data);
      end
    end
    if (prev_req && !drv_req && !prev_done) r11_bad++;
    prev_req  = drv_req;
    prev_done = drv_done;
  end

  task automatic wait_idle();
    do begin @(negedge clk); #3; end
    while (cmdq.size() > 0 || rq_valid || expq.size() > 0 || hd_valid);
    repeat (3) @(negedge clk);
  endtask

  task automatic drop_enable();
    @(negedge clk);
    ra_enable = 1'b0;
    #2;
    hidx = widx + ((drv_req && !drv_done) ? 1 : 0);
    tag_flush = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7 watchdog expired", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    chk(drv_req == 1'b0, "R1 drv_req in reset", 32'(drv_req), 32'h0);
    chk(hd_valid == 1'b0, "R1 hd_valid in reset", 32'(hd_valid), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(drv_req == 1'b0, "R1 no fetch without request", 32'(drv_req), 32'h0);
    chk(hd_valid == 1'b0, "R1 no result after reset", 32'(hd_valid), 32'h0);

    // mixed sizes, two latencies: R5 R6 R7
    drv_lat = 2;
    cmdq = '{0, 0, 1, 0, 1, 1, 1, 0};
    wait_idle();
    drv_lat = 0;
    cmdq = '{1, 1, 0, 1, 0, 0, 1};
    wait_idle();

    // R2: host stalled, queue fills to four and fetching stops
    drop_enable();
    repeat (3) @(negedge clk);
    ra_enable = 1'b1;
    hd_ready  = 1'b0;
    w0 = widx;
    cmdq = '{0, 0, 0};
    repeat (60) @(negedge clk);
    chk(widx - w0 == 5, "R2 words fetched while stalled", 32'(widx - w0), 32'd5);
    chk(drv_req == 1'b0, "R2 no fetch when full", 32'(drv_req), 32'h0);
    begin
      logic [31:0] held;
      held = hd_data;
      chk(hd_valid == 1'b1, "R8 result pending", 32'(hd_valid), 32'h1);
      repeat (5) @(negedge clk);
      #1;
      chk(hd_valid && hd_data == held, "R8 result held", hd_data, held);
      chk(rq_ready == 1'b0, "R8 no accept while slot blocked", 32'(rq_ready), 32'h0);
    end
    hd_ready = 1'b1;
    wait_idle();

    // R3/R4: 4-byte sector bounds prefetch at two words, then reloads
    drop_enable();
    sector_bytes = CW'(4);
    repeat (3) @(negedge clk);
    ra_enable = 1'b1;
    hd_ready  = 1'b0;
    w0 = widx;
    cmdq = '{0, 0, 0};
    repeat (40) @(negedge clk);
    chk(widx - w0 == 2, "R3 fetch bounded by sector", 32'(widx - w0), 32'd2);
    chk(drv_req == 1'b0, "R3 idle at counter zero", 32'(drv_req), 32'h0);
    hd_ready = 1'b1;
    wait_idle();
    chk(widx - w0 >= 3, "R4 reload resumes fetch", 32'(widx - w0), 32'd3);

    // R9/R10: on-demand mode after flush
    drop_enable();
    sector_bytes = CW'(64);
    repeat (3) @(negedge clk);
    w0 = widx;
    cmdq = '{0};
    wait_idle();
    chk(widx - w0 == 1, "R9 one read for word", 32'(widx - w0), 32'd1);
    cmdq = '{1};
    wait_idle();
    chk(widx - w0 == 3, "R9 two reads for doubleword", 32'(widx - w0), 32'd3);
    repeat (20) @(negedge clk);
    chk(widx - w0 == 3, "R9 no read-ahead when off", 32'(widx - w0), 32'd3);

    // R10: flush while a prefetch cycle is in flight
    @(negedge clk);
    ra_enable = 1'b1;
    drv_lat   = 15;
    hd_ready  = 1'b0;
    w0 = widx;
    cmdq = '{0, 0};
    do @(negedge clk); while (!(hd_valid && drv_req));
    drop_enable();
    hd_ready = 1'b1;
    drv_lat  = 1;
    wait_idle();
    chk(widx - w0 == 3, "R10 in-flight word discarded", 32'(widx - w0), 32'd3);

    chk(expq.size() == 0, "R7 all results delivered", 32'(expq.size()), 32'h0);
    chk(r11_bad == 0, "R11 request held until done", 32'(r11_bad), 32'h0);
    summary();
    $finish;
  end
endmodule